// File: doc/BRIEF.md
# Maskable Event Status and Interrupt Controller

This block gathers single-cycle event pulses from a bus-master and DMA datapath into a byte of sticky status bits. It then drives one active-low, level-sensitive interrupt line toward the host. Each of the eight primary sources has its own enable bit. A source whose enable is clear is ignored entirely: its status bit never sets, so it cannot raise the line. Two more sources, a FIFO fault and an interrupt forwarded from the local processing core, are enabled by bits in the control byte and report in a second status byte.

The host reaches four byte registers through a small read/write port. The enable register and the control register can be read and written. The two status registers are read-only, and every bit in them clears as a side effect of the read that returns it. The control byte also holds a global pin-mute bit. This bit holds the line inactive but does not stop status from collecting, so software can poll even with the line muted.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the control register reads 0x41 (pin mute at bit 0 = 1, FIFO-fault enable at bit 6 = 1, local enable at bit 7 = 0), both status registers read 0x00 and `irq_n` is 1.
- R2: A pulse on `pri_evt[i]` while enable bit i is 1 sets bit i of the primary status byte (address 2) at the next clock edge. The bit order is: 0 target abort received, 1 DMA abort, 2 DMA end, 3 target abort signalled, 4 master abort, 5 master parity error, 6 data parity error, 7 address parity error.
- R3: A pulse on a source whose enable bit is 0 leaves its status bit at 0 and does not pull `irq_n` low.
- R4: A read of a status address returns the bits held before that read. All bits of that status byte are 0 from the following clock edge.
- R5: An enabled event that arrives in the same cycle as a read of its status byte is still set after the read-clear.
- R6: While control bit 0 is 1, `irq_n` stays 1, but enabled events still set status bits.
- R7: `irq_n` is a register. After every clock edge it is 0 exactly when control bit 0 is 0 and at least one status bit in either byte is 1.
- R8: `fifo_err_evt` sets bit 6 of the extra status byte (address 3) only when control bit 6 is 1. `local_evt` sets bit 7 of that byte only when control bit 7 is 1.
- R9: Address 0 (enable) stores all 8 written bits. Address 1 (control) stores bits 0, 6 and 7, and its other bits read 0. Writes to addresses 2 and 3 change nothing.
- R10: Clearing control bit 0 while status is already pending pulls `irq_n` low at the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_evt | input | NUM_PRI | Primary event pulses, one per source |
| fifo_err_evt | input | 1 | FIFO fault event pulse |
| local_evt | input | 1 | Forwarded local-core interrupt pulse |
| reg_addr | input | 2 | Register select: 0 enable, 1 control, 2 primary status, 3 extra status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of a status address clears it |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle, 0 when not reading |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The assertions assume that events are single-cycle pulses sampled on the clock edge. They also assume that a strobe lasts one cycle, so a held read counts as repeated clears. The bench drives every input at the falling edge, so each pulse and each strobe covers exactly one rising edge. It mixes directed cases, such as a read colliding with a new event and a change to the mute or enable bit while status is pending, with a long stretch of random pulses, writes and reads held within that same one-edge discipline.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_ENABLE = 2'd0,
      RA_CTRL   = 2'd1,
      RA_PSTAT  = 2'd2,
      RA_XSTAT  = 2'd3
   } reg_addr_e;

   // control byte layout
   localparam int CTL_MUTE     = 0;
   localparam int CTL_FIFO_EN  = 6;
   localparam int CTL_LOCAL_EN = 7;
   localparam logic [DATA_W-1:0] CTL_MASK  = 8'hC1;
   localparam logic [DATA_W-1:0] CTL_RESET = 8'h41;

   // extra sources occupy the top two bits of their status byte
   localparam int XTRA_N  = 2;
   localparam int XTRA_LO = 6;
endpackage

// File: rtl/evt_irq_capture.sv
module evt_irq_capture #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] en,
   input  logic         clr,
   output logic [W-1:0] stat_d,
   output logic [W-1:0] stat_q
);
   if (W < 1) begin : g_bad_w
      $error("evt_irq_capture: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      // new events win over the read-clear
      assign stat_d[i] = (stat_q[i] & ~clr) | (evt[i] & en[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[i] <= 1'b0;
         else        stat_q[i] <= stat_d[i];
      end
   end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int NUM_PRI = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_PRI-1:0] en_q,
   output logic [DATA_W-1:0]  ctrl_q,
   output logic               mute_d
);
   logic wr_en_reg, wr_ctrl_reg;

   assign wr_en_reg   = wr && (addr == RA_ENABLE);
   assign wr_ctrl_reg = wr && (addr == RA_CTRL);
   assign mute_d      = wr_ctrl_reg ? wdata[CTL_MUTE] : ctrl_q[CTL_MUTE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         ctrl_q <= CTL_RESET;
      end else begin
         if (wr_en_reg)   en_q   <= wdata[NUM_PRI-1:0];
         if (wr_ctrl_reg) ctrl_q <= wdata & CTL_MASK;
      end
   end
endmodule

// File: rtl/evt_irq_pin.sv
module evt_irq_pin #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mute_d,
   input  logic any_d,
   input  logic mute_q,
   input  logic any_q,
   output logic irq_n
);
   if (IRQ_REG) begin : g_reg
      logic unused_q;
      assign unused_q = mute_q ^ any_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~(~mute_d & any_d);
      end
   end else begin : g_comb
      logic unused_d;
      assign unused_d = mute_d ^ any_d ^ clk ^ rst_n;
      assign irq_n = ~(~mute_q & any_q);
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int NUM_PRI = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_PRI-1:0] pri_evt,
   input  logic               fifo_err_evt,
   input  logic               local_evt,
   input  logic [1:0]         reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               irq_n
);
   if (NUM_PRI < 1 || NUM_PRI > DATA_W) begin : g_bad_pri
      $error("evt_irq_ctrl: NUM_PRI must be 1..DATA_W");
   end

   logic [NUM_PRI-1:0] pri_en_q, pri_stat_d, pri_stat_q;
   logic [DATA_W-1:0]  ctrl_q;
   logic [XTRA_N-1:0]  xtra_evt, xtra_en, xtra_stat_d, xtra_stat_q;
   logic               mute_d, pclr, xclr;
   logic [DATA_W-1:0]  pri_byte, xtra_byte;

   evt_irq_regs #(.NUM_PRI(NUM_PRI)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .en_q(pri_en_q), .ctrl_q(ctrl_q), .mute_d(mute_d)
   );

   assign pclr = reg_rd && (reg_addr == RA_PSTAT);
   assign xclr = reg_rd && (reg_addr == RA_XSTAT);

   evt_irq_capture #(.W(NUM_PRI)) pcap_i (
      .clk(clk), .rst_n(rst_n), .evt(pri_evt), .en(pri_en_q), .clr(pclr),
      .stat_d(pri_stat_d), .stat_q(pri_stat_q)
   );

   assign xtra_evt = {local_evt, fifo_err_evt};
   assign xtra_en  = {ctrl_q[CTL_LOCAL_EN], ctrl_q[CTL_FIFO_EN]};

   evt_irq_capture #(.W(XTRA_N)) xcap_i (
      .clk(clk), .rst_n(rst_n), .evt(xtra_evt), .en(xtra_en), .clr(xclr),
      .stat_d(xtra_stat_d), .stat_q(xtra_stat_q)
   );

   evt_irq_pin #(.IRQ_REG(IRQ_REG)) pin_i (
      .clk(clk), .rst_n(rst_n),
      .mute_d(mute_d), .any_d((|pri_stat_d) | (|xtra_stat_d)),
      .mute_q(ctrl_q[CTL_MUTE]), .any_q((|pri_stat_q) | (|xtra_stat_q)),
      .irq_n(irq_n)
   );

   always_comb begin
      pri_byte = '0;
      pri_byte[NUM_PRI-1:0] = pri_en_q;
      xtra_byte = '0;
      xtra_byte[XTRA_LO +: XTRA_N] = xtra_stat_q;
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (reg_addr)
            RA_ENABLE: reg_rdata = pri_byte;
            RA_CTRL:   reg_rdata = ctrl_q;
            RA_PSTAT: begin
               reg_rdata = '0;
               reg_rdata[NUM_PRI-1:0] = pri_stat_q;
            end
            default:   reg_rdata = xtra_byte;
         endcase
      end
   end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
   parameter int NUM_PRI = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_PRI-1:0] pri_evt,
   input logic               fifo_err_evt,
   input logic               local_evt,
   input logic [1:0]         reg_addr,
   input logic               reg_rd,
   input logic               irq_n,
   input logic [NUM_PRI-1:0] pri_en_q,
   input logic [7:0]         ctrl_q,
   input logic [NUM_PRI-1:0] pri_stat_q,
   input logic [1:0]         xtra_stat_q
);
   for (genvar i = 0; i < NUM_PRI; i++) begin : g_p
      a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
         (pri_evt[i] && pri_en_q[i]) |=> pri_stat_q[i]);
      a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
         (!pri_en_q[i] && !pri_stat_q[i]) |=> !pri_stat_q[i]);
      a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd && reg_addr == 2'd2 && !(pri_evt[i] && pri_en_q[i])) |=> !pri_stat_q[i]);
   end

   a_r8_fifo_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[6] && !xtra_stat_q[0]) |=> !xtra_stat_q[0]);
   a_r8_local_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[7] && !xtra_stat_q[1]) |=> !xtra_stat_q[1]);
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_err_evt && ctrl_q[6]) |=> xtra_stat_q[0]);
   a_r6_muted: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[0] |-> irq_n);
   a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && (pri_stat_q != '0 || xtra_stat_q != '0)) |-> !irq_n);
endmodule

bind evt_irq_ctrl evt_irq_chk #(.NUM_PRI(NUM_PRI)) chk_i (
   .clk(clk), .rst_n(rst_n), .pri_evt(pri_evt), .fifo_err_evt(fifo_err_evt),
   .local_evt(local_evt), .reg_addr(reg_addr), .reg_rd(reg_rd), .irq_n(irq_n),
   .pri_en_q(pri_en_q), .ctrl_q(ctrl_q), .pri_stat_q(pri_stat_q),
   .xtra_stat_q(xtra_stat_q)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pri_evt = '0;
   logic       fifo_err_evt = 1'b0, local_evt = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_n;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference state
   byte unsigned m_en = 0, m_ctrl = 8'h41, m_ps = 0, m_xs = 0;

   always #2 clk = ~clk;

   evt_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pri_evt(pri_evt), .fifo_err_evt(fifo_err_evt),
      .local_evt(local_evt), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit rd, input bit wr, input logic [1:0] a, input byte unsigned wd,
                      input byte unsigned pe, input bit fe, input bit le);
      byte unsigned exp_rd;
      bit exp_irq;
      @(negedge clk);
      reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      pri_evt = pe; fifo_err_evt = fe; local_evt = le;
      #1;
      exp_irq = !(!m_ctrl[0] && (m_ps != 0 || m_xs != 0));
      check(m_ctrl[0] ? "R6" : cur_req, int'(irq_n), int'(exp_irq));
      if (rd) begin
         case (a)
            2'd0: exp_rd = m_en;
            2'd1: exp_rd = m_ctrl;
            2'd2: exp_rd = m_ps;
            default: exp_rd = m_xs;
         endcase
         check(cur_req, int'(reg_rdata), int'(exp_rd));
      end
      @(posedge clk);
      if (rd && a == 2'd2) m_ps = 0;
      if (rd && a == 2'd3) m_xs = 0;
      m_ps = m_ps | (pe & m_en);
      if (fe && m_ctrl[6]) m_xs = m_xs | 8'h40;
      if (le && m_ctrl[7]) m_xs = m_xs | 8'h80;
      if (wr && a == 2'd0) m_en = wd;
      if (wr && a == 2'd1) m_ctrl = wd & 8'hC1;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic rd(input logic [1:0] a);
      cyc(1, 0, a, 0, 0, 0, 0);
   endtask
   task automatic wr(input logic [1:0] a, input byte unsigned d);
      cyc(0, 1, a, d, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset values
      cur_req = "R1";
      check("R1", int'(irq_n), 1);
      rd(0); rd(1); rd(2); rd(3);
      // R9 register access
      cur_req = "R9";
      wr(0, 8'hFF); rd(0);
      wr(1, 8'hFF); rd(1);
      wr(2, 8'hFF); wr(3, 8'hFF); rd(2); rd(3);
      wr(1, 8'h00); rd(1);
      // R2 each primary source at its bit position
      cur_req = "R2";
      for (int i = 0; i < 8; i++) begin
         cyc(0, 0, 0, 0, 8'(1 << i), 0, 0);
         idle();
         rd(2);
         idle();
      end
      // R3 masked sources
      cur_req = "R3";
      wr(0, 8'h0F);
      cyc(0, 0, 0, 0, 8'hF0, 0, 0);
      idle(); rd(2);
      // R5 collision of event and read-clear
      cur_req = "R5";
      cyc(0, 0, 0, 0, 8'h02, 0, 0);
      cyc(1, 0, 2, 0, 8'h01, 0, 0);
      idle(); rd(2); rd(2);
      // R6 muted pin still collects status
      cur_req = "R6";
      wr(1, 8'h01);
      cyc(0, 0, 0, 0, 8'h04, 0, 0);
      idle(); idle();
      // R10 unmute with pending status
      cur_req = "R10";
      wr(1, 8'h00);
      idle();
      rd(2); idle();
      // R4 read returns old value then clears
      cur_req = "R4";
      cyc(0, 0, 0, 0, 8'h09, 0, 0);
      rd(2); rd(2);
      // R8 extra sources
      cur_req = "R8";
      cyc(0, 0, 0, 0, 0, 1, 1);
      rd(3);
      wr(1, 8'hC0);
      cyc(0, 0, 0, 0, 0, 1, 1);
      rd(3); rd(3);
      wr(1, 8'h80);
      cyc(0, 0, 0, 0, 0, 1, 0);
      rd(3);
      // R7 random traffic compared every cycle
      cur_req = "R7";
      for (int k = 0; k < 400; k++) begin
         logic [1:0] a;
         bit r, w;
         a = 2'($urandom_range(0, 3));
         r = ($urandom_range(0, 3) == 0);
         w = ($urandom_range(0, 7) == 0);
         cyc(r, w, a, 8'($urandom), 8'($urandom & $urandom),
             ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
      end
      finish_run();
   end
endmodule